// File: doc/BRIEF.md
# Predicated Sign-Extending Byte-Load Sequencer

This block executes one predicated vector load of signed bytes. A request gives a destination element width (16, 32 or 64 bits), a 64-bit base, a 64-bit index, a predicate with one bit per vector byte, and a flag that marks the base as the stack pointer. The block walks the elements in ascending order. For each active element it issues one single-byte read on a simple memory port. It then sign-extends the returned byte to the element width and places it in a vector-length result register.

Inactive elements cost one cycle each. They produce no memory traffic and leave their lanes at zero. A stack-pointer base that is not 16-byte aligned ends the request at once with a fault pulse. The result register keeps its value after completion until the next request is accepted.

Top module: `sext_byte_load_seq`

## Requirements
- R1: `reqReady` is high exactly while the block is idle. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high.
- R2: The first element address is `reqBase + reqIndex`. Each following element uses the previous address plus one, whether or not the element is active. All address arithmetic wraps modulo 2^64.
- R3: `reqElemSize` selects the element width: 2'b00 gives 16 bits, 2'b01 gives 32 bits, and 2'b10 or 2'b11 give 64 bits. The element count is `VLEN_BITS` divided by the width.
- R4: Element e is active when predicate bit e*(width/8) is set. The other predicate bits of that element's byte group have no effect.
- R5: An inactive element issues no memory read, and its lanes in `resultOut` are zero.
- R6: For an active element, `resultOut[e*width +: width]` holds the returned byte with bit 7 copied into all upper bits.
- R7: At most one memory read is outstanding. `memReqValid` stays high with a stable `memReqAddr` until `memReqReady` is seen, and no new read starts before `memRspValid` returns the byte.
- R8: Completion is a single-cycle `doneOut` pulse. `resultOut` then stays unchanged until the next request is accepted.
- R9: When `reqBaseIsSp` is set, `reqBase[3:0]` is nonzero and at least one element is active, `faultOut` and `doneOut` pulse together in the first cycle after acceptance. No memory read is issued and `resultOut` is zero.
- R10: A misaligned stack-pointer base with no active element faults in the same way when `SP_CHECK_NONE_ACTIVE` is 1 (the default). When it is 0, the request completes without a fault.
- R11: When no element is active and there is no fault, `doneOut` rises in the cycle after the element-count clock edges that follow acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request can be taken |
| reqElemSize | input | 2 | Element width code |
| reqBase | input | 64 | Base address |
| reqIndex | input | 64 | Byte index added to the base |
| reqPred | input | VLEN_BITS/8 | Predicate, one bit per vector byte |
| reqBaseIsSp | input | 1 | Base is the stack pointer |
| memReqValid | output | 1 | Byte read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | Byte address of the read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 8 | Returned byte |
| doneOut | output | 1 | One-cycle completion pulse |
| faultOut | output | 1 | One-cycle alignment fault pulse |
| resultOut | output | VLEN_BITS | Packed sign-extended result |

## Verification
The bench samples every output on the falling edge. It detects acceptance at the falling edge just before the accepting rising edge. An alignment fault must show `faultOut` and `doneOut` at the very next falling edge. A request with no active element must show `doneOut` at the falling edge that lies one more than the element count after acceptance. Any earlier or later pulse fails. For requests that read memory, the done cycle depends on memory latency, so the bench instead checks each handshake address in order as it happens, checks the full result on the done pulse, and checks that the result is unchanged on every idle cycle after it.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef struct packed {
    logic load;
    logic adv;
    logic wr;
  } bls_strobe_t;

  typedef struct packed {
    logic active;
    logic last;
    logic startFault;
  } bls_status_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK,
    ST_WAIT,
    ST_DONE,
    ST_FAULT
  } bls_state_t;

  // element-size code -> log2(element bits / 16)
  function automatic logic [1:0] sizeShift(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/bls_req_check.sv
module bls_req_check
  import bls_pkg::*;
#(
  parameter int VLEN_BITS            = 256,
  parameter int ADDR_W               = 64,
  parameter int SP_ALIGN_LOG2        = 4,
  parameter bit SP_CHECK_NONE_ACTIVE = 1'b1
) (
  input  logic [1:0]             reqElemSize,
  input  logic [ADDR_W-1:0]      reqBase,
  input  logic [VLEN_BITS/8-1:0] reqPred,
  input  logic                   reqBaseIsSp,
  output logic                   startFault
);
  localparam int PRED_W = VLEN_BITS / 8;

  logic [1:0] shiftReq;
  logic       anyActive;
  logic       misaligned;
  int unsigned groupMask;

  always_comb begin
    shiftReq  = sizeShift(reqElemSize);
    groupMask = (32'd2 << shiftReq) - 32'd1;
    anyActive = 1'b0;
    for (int j = 0; j < PRED_W; j++) begin
      if (((j & groupMask) == 0) && reqPred[j]) anyActive = 1'b1;
    end
  end

  assign misaligned = |reqBase[SP_ALIGN_LOG2-1:0];
  assign startFault = reqBaseIsSp && misaligned && (anyActive || SP_CHECK_NONE_ACTIVE);

endmodule

// File: rtl/bls_datapath.sv
module bls_datapath
  import bls_pkg::*;
#(
  parameter int VLEN_BITS            = 256,
  parameter int ADDR_W               = 64,
  parameter int SP_ALIGN_LOG2        = 4,
  parameter bit SP_CHECK_NONE_ACTIVE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bls_strobe_t            strobe,
  input  logic [1:0]             reqElemSize,
  input  logic [ADDR_W-1:0]      reqBase,
  input  logic [ADDR_W-1:0]      reqIndex,
  input  logic [VLEN_BITS/8-1:0] reqPred,
  input  logic                   reqBaseIsSp,
  input  logic [7:0]             memRspData,
  output bls_status_t            status,
  output logic [ADDR_W-1:0]      curAddr,
  output logic [VLEN_BITS-1:0]   result
);
  localparam int PRED_W = VLEN_BITS / 8;
  localparam int SLOTS  = VLEN_BITS / 16;
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int PP_W   = (PRED_W > 1) ? $clog2(PRED_W) : 1;

  logic [1:0]           shiftQ;
  logic [PRED_W-1:0]    predQ;
  logic [IDX_W-1:0]     idxQ;
  logic [ADDR_W-1:0]    addrQ;
  logic [VLEN_BITS-1:0] resultQ;

  logic [PP_W-1:0]      predPos;
  logic [IDX_W-1:0]     lastIdx;
  logic                 reqFault;

  logic [SLOTS-1:0]     slotHit;
  logic [15:0]          slotVal [SLOTS];

  bls_req_check #(
    .VLEN_BITS(VLEN_BITS),
    .ADDR_W(ADDR_W),
    .SP_ALIGN_LOG2(SP_ALIGN_LOG2),
    .SP_CHECK_NONE_ACTIVE(SP_CHECK_NONE_ACTIVE)
  ) u_check (
    .reqElemSize(reqElemSize),
    .reqBase(reqBase),
    .reqPred(reqPred),
    .reqBaseIsSp(reqBaseIsSp),
    .startFault(reqFault)
  );

  // lowest predicate bit of the current element's byte group
  always_comb begin
    predPos = PP_W'({idxQ, 1'b0}) << shiftQ;
    lastIdx = IDX_W'(SLOTS - 1) >> shiftQ;
  end

  assign status.active     = predQ[predPos];
  assign status.last       = (idxQ == lastIdx);
  assign status.startFault = reqFault;

  // 16-bit slots: the low slot of an element takes the extended byte,
  // higher slots of the same element take the sign fill
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int unsigned SLOT_ID = s;
    logic [IDX_W-1:0] elemOf;
    logic             lowSlot;
    always_comb begin
      elemOf     = IDX_W'(SLOT_ID >> shiftQ);
      lowSlot    = (SLOT_ID & ((32'd1 << shiftQ) - 32'd1)) == 0;
      slotHit[s] = strobe.wr && (elemOf == idxQ);
      slotVal[s] = lowSlot ? {{8{memRspData[7]}}, memRspData} : {16{memRspData[7]}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      predQ   <= '0;
      idxQ    <= '0;
      addrQ   <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.load) begin
        shiftQ  <= sizeShift(reqElemSize);
        predQ   <= reqPred;
        idxQ    <= '0;
        addrQ   <= reqBase + reqIndex;
        resultQ <= '0;
      end else begin
        if (strobe.adv) begin
          idxQ  <= idxQ + 1'b1;
          addrQ <= addrQ + 1'b1;
        end
        for (int s = 0; s < SLOTS; s++) begin
          if (slotHit[s]) resultQ[s*16 +: 16] <= slotVal[s];
        end
      end
    end
  end

  assign curAddr = addrQ;
  assign result  = resultQ;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.adv && !strobe.load |=> addrQ == $past(addrQ) + 1'b1) else $error("addr step"); // R2
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> resultQ == '0) else $error("result not cleared"); // R5

endmodule

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  bls_status_t status,
  output bls_strobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        doneOut,
  output logic        faultOut
);
  bls_state_t stateQ, stateNxt;

  always_comb begin
    stateNxt    = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    doneOut     = 1'b0;
    faultOut    = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNxt    = status.startFault ? ST_FAULT : ST_WALK;
        end
      end
      ST_WALK: begin
        if (status.active) begin
          memReqValid = 1'b1;
          if (memReqReady) stateNxt = ST_WAIT;
        end else begin
          strobe.adv = 1'b1;
          if (status.last) stateNxt = ST_DONE;
        end
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.wr  = 1'b1;
          strobe.adv = 1'b1;
          stateNxt   = status.last ? ST_DONE : ST_WALK;
        end
      end
      ST_DONE: begin
        doneOut  = 1'b1;
        stateNxt = ST_IDLE;
      end
      ST_FAULT: begin
        doneOut  = 1'b1;
        faultOut = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut) else $error("done held"); // R8
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |-> doneOut && !memReqValid) else $error("fault without done"); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid) else $error("request dropped"); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && reqValid |=> !reqReady) else $error("ready while busy"); // R1

endmodule

// File: rtl/sext_byte_load_seq.sv
module sext_byte_load_seq
  import bls_pkg::*;
#(
  parameter int VLEN_BITS            = 256,
  parameter int ADDR_W               = 64,
  parameter int SP_ALIGN_LOG2        = 4,
  parameter bit SP_CHECK_NONE_ACTIVE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [1:0]             reqElemSize,
  input  logic [ADDR_W-1:0]      reqBase,
  input  logic [ADDR_W-1:0]      reqIndex,
  input  logic [VLEN_BITS/8-1:0] reqPred,
  input  logic                   reqBaseIsSp,
  output logic                   memReqValid,
  input  logic                   memReqReady,
  output logic [ADDR_W-1:0]      memReqAddr,
  input  logic                   memRspValid,
  input  logic [7:0]             memRspData,
  output logic                   doneOut,
  output logic                   faultOut,
  output logic [VLEN_BITS-1:0]   resultOut
);
  bls_strobe_t strobe;
  bls_status_t status;

  bls_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .status(status),
    .strobe(strobe),
    .reqReady(reqReady),
    .memReqValid(memReqValid),
    .doneOut(doneOut),
    .faultOut(faultOut)
  );

  bls_datapath #(
    .VLEN_BITS(VLEN_BITS),
    .ADDR_W(ADDR_W),
    .SP_ALIGN_LOG2(SP_ALIGN_LOG2),
    .SP_CHECK_NONE_ACTIVE(SP_CHECK_NONE_ACTIVE)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .reqElemSize(reqElemSize),
    .reqBase(reqBase),
    .reqIndex(reqIndex),
    .reqPred(reqPred),
    .reqBaseIsSp(reqBaseIsSp),
    .memRspData(memRspData),
    .status(status),
    .curAddr(memReqAddr),
    .result(resultOut)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr)) else $error("addr moved"); // R7
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid) else $error("second read"); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && !reqValid |=> $stable(resultOut)) else $error("result moved"); // R8

endmodule

// File: tb/sext_byte_load_seq_tb.sv
module sext_byte_load_seq_tb;
  localparam int VL = 256;
  localparam int PW = VL / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqElemSize = '0;
  logic [63:0]   reqBase = '0;
  logic [63:0]   reqIndex = '0;
  logic [PW-1:0] reqPred = '0;
  logic          reqBaseIsSp = 1'b0;
  logic          memReqValid;
  logic          memReqReady = 1'b0;
  logic [63:0]   memReqAddr;
  logic          memRspValid = 1'b0;
  logic [7:0]    memRspData = '0;
  logic          doneOut;
  logic          faultOut;
  logic [VL-1:0] resultOut;

  sext_byte_load_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqElemSize(reqElemSize), .reqBase(reqBase), .reqIndex(reqIndex),
    .reqPred(reqPred), .reqBaseIsSp(reqBaseIsSp),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .doneOut(doneOut), .faultOut(faultOut), .resultOut(resultOut)
  );

  always #10 clk = ~clk;

  int testCount = 0;
  int failCount = 0;
  int cycle = 0;

  // reference state
  logic [63:0]   expAddrQ[$];
  logic [VL-1:0] expResult;
  logic          expFault;
  int            expDoneRel;   // -1 = latency dependent
  int            acceptCyc;
  logic          busy = 1'b0;
  logic [VL-1:0] lastResult;
  logic          haveLast = 1'b0;
  logic          prevDone = 1'b0;
  int            memLat = 1;
  logic [7:0]    readyPat = 8'hFF;
  int            pend = 0;
  logic [63:0]   pendAddr;

  function automatic logic [7:0] memByte(input logic [63:0] a);
    return 8'(a[7:0] * 8'd37 + a[15:8] + 8'h5B);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [VL-1:0] act, input logic [VL-1:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model, sampled on the falling edge
  always @(negedge clk) begin
    cycle++;
    if (rstN) begin
      logic newReady;
      memRspValid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          memRspValid = 1'b1;
          memRspData  = memByte(pendAddr);
        end
      end
      if (memReqValid && (pend > 0 || memRspValid))
        check(1'b0, "R7", "read while one outstanding", VL'(memReqAddr), '0);
      newReady = readyPat[cycle % 8];
      memReqReady = newReady;
      if (memReqValid && newReady) begin
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R5", "unexpected read", VL'(memReqAddr), '0);
        end else begin
          logic [63:0] e;
          e = expAddrQ.pop_front();
          check(memReqAddr == e, "R2", "read address", VL'(memReqAddr), VL'(e));
        end
        pendAddr = memReqAddr;
        pend = memLat;
      end
      if (reqReady != !busy) check(1'b0, "R1", "reqReady", VL'(reqReady), VL'(!busy));
      if (faultOut && !doneOut) check(1'b0, "R9", "fault without done", 1, 0);
      if (doneOut && prevDone) check(1'b0, "R8", "done longer than one cycle", 1, 0);
      if (doneOut) begin
        check(busy, "R8", "done while idle", VL'(busy), 1);
        check(resultOut == expResult, "R6 R5 R4", "result", resultOut, expResult);
        check(faultOut == expFault, "R9 R10", "fault flag", VL'(faultOut), VL'(expFault));
        check(expAddrQ.size() == 0, "R5", "reads left", VL'(expAddrQ.size()), 0);
        if (expDoneRel >= 0)
          check(cycle - acceptCyc == expDoneRel, "R11 R9", "done cycle",
                VL'(cycle - acceptCyc), VL'(expDoneRel));
        busy = 1'b0;
        lastResult = resultOut;
        haveLast = 1'b1;
      end else if (!busy && haveLast) begin
        check(resultOut == lastResult, "R8", "result held", resultOut, lastResult);
      end
      if (reqValid && reqReady) begin
        busy = 1'b1;
        acceptCyc = cycle;
      end
      prevDone = doneOut;
    end
  end

  task automatic runReq(input logic [1:0] code, input logic [63:0] base, input logic [63:0] idx,
                        input logic [PW-1:0] pred, input logic sp, input int lat,
                        input logic [7:0] pat);
    int es, n;
    logic anyAct;
    logic [63:0] start;
    es = (code == 2'b00) ? 16 : (code == 2'b01) ? 32 : 64;
    n = VL / es;
    start = base + idx;
    anyAct = 1'b0;
    expResult = '0;
    expAddrQ.delete();
    for (int e = 0; e < n; e++) if (pred[e * es / 8]) anyAct = 1'b1;
    expFault = sp && (base[3:0] != 4'd0);
    if (expFault) begin
      expDoneRel = 1;
    end else begin
      for (int e = 0; e < n; e++) begin
        if (pred[e * es / 8]) begin
          logic [7:0] d;
          d = memByte(start + 64'(e));
          expAddrQ.push_back(start + 64'(e));
          for (int b = 0; b < es; b++) expResult[e * es + b] = (b < 8) ? d[b] : d[7];
        end
      end
      expDoneRel = anyAct ? -1 : n + 1;
    end
    memLat = lat;
    readyPat = pat;
    @(posedge clk); #2;
    reqElemSize = code; reqBase = base; reqIndex = idx; reqPred = pred; reqBaseIsSp = sp;
    reqValid = 1'b1;
    @(posedge clk); #2;
    reqValid = 1'b0;
    reqPred = '1;
    reqBase = ~base;
    while (busy) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL R8 watchdog: actual no completion expected done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !doneOut && !faultOut && !memReqValid && resultOut == '0,
          "R1", "reset state", {reqReady, doneOut, faultOut, memReqValid}, 4'b1000);
    // R3 R6: 16-bit elements, all active
    runReq(2'b00, 64'h1000, 64'h20, '1, 1'b0, 1, 8'hFF);
    // R4: 32-bit, alternating groups, stalling memory
    runReq(2'b01, 64'h2000_0000_0000_0040, 64'h3, 32'h0F0F_0F0F, 1'b0, 3, 8'b1010_0110);
    // R4 R5: 64-bit, only non-lowest bits of groups 0 and 2 set, group 1 and 3 active
    runReq(2'b10, 64'h500, 64'h7, 32'h01FE_01FE, 1'b0, 2, 8'b0110_1101);
    // R3: code 2'b11 behaves as 64-bit
    runReq(2'b11, 64'h700, 64'h0, 32'h0101_0101, 1'b0, 1, 8'hFF);
    // R11: nothing active, 16-bit
    runReq(2'b00, 64'h800, 64'h1, 32'hAAAA_AAAA, 1'b0, 1, 8'hFF);
    // R11: nothing active, 64-bit
    runReq(2'b10, 64'h800, 64'h1, '0, 1'b0, 1, 8'hFF);
    // R9: aligned stack pointer loads normally
    runReq(2'b01, 64'hFF0, 64'h5, 32'h0000_1111, 1'b1, 1, 8'hFF);
    // R9: misaligned stack pointer with active elements faults
    runReq(2'b00, 64'hFF4, 64'h0, 32'h0000_0005, 1'b1, 1, 8'hFF);
    // R10: misaligned stack pointer, no active element, default parameter faults
    runReq(2'b01, 64'hFF8, 64'h0, 32'hEEEE_EEEE, 1'b1, 1, 8'hFF);
    // R9: misaligned base that is not the stack pointer loads normally
    runReq(2'b00, 64'hFF4, 64'h0, 32'h0000_0005, 1'b0, 2, 8'hFF);
    // R2: address wraps past 2^64
    runReq(2'b00, 64'hFFFF_FFFF_FFFF_FFF8, 64'h4, '1, 1'b0, 1, 8'b1101_1011);
    // R7: long latency with sparse ready
    runReq(2'b10, 64'h9000, 64'h11, 32'h0101_0101, 1'b0, 6, 8'b1000_0001);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule